// File: doc/BRIEF.md
# Real-Time-Clock Alarm Matcher

This block decides when a real-time-clock alarm fires. Once per second, right after the time-keeping logic has refreshed its seconds, minutes, hours and date values, the clock domain pulses `sec_tick`. The matcher compares the current BCD time with four alarm registers. The top bit of each alarm register is a repeat-mask bit. Read together, these four bits select how many of the lower fields must agree before the alarm fires. A hit on that tick raises a sticky alarm flag. The interrupt output follows the flag, but only when the flag enable is set. While the system runs on backup power, the interrupt also needs a second enable.

The flag is cleared by reading the flags register. The bus logic outside the block reports two things: that the flags register is the currently latched address (`flags_sel`), and that a read strobe is active (`flags_rd`). A hit that arrives while the flags address is latched is not lost. It is held back, and the flag rises only once some other address has been latched. This way a read that is already in progress cannot swallow a fresh alarm.

The flag logic is a three-state machine:
- `FL_IDLE`: flag low.
- `FL_PEND`: a hit was seen while the flags address was latched.
- `FL_SET`: flag high.

Its transitions are:
- IDLE→SET: a hit with `flags_sel` low.
- IDLE→PEND: a hit with `flags_sel` high.
- PEND→SET: `flags_sel` falls.
- SET→IDLE: a flags read with no hit.
- SET→PEND: a flags read in the same cycle as a hit.

Every other case holds the current state.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: During and right after reset, `alarm_flag` and `alarm_irq` are 0.
- R2: The repeat code is {date[7], hour[7], min[7], sec[7]}. Code 1111 fires on every tick. Code 1110 compares seconds. Code 1100 compares seconds and minutes. Code 1000 adds hours. Code 0000 adds the date.
- R3: Any repeat code outside the five listed in R2 behaves as 1111 and fires on every tick.
- R4: A hit on a cycle with `sec_tick` high sets `alarm_flag` on the following clock edge. Without a tick, the flag never rises except from a deferred hit.
- R5: Outside backup mode, `alarm_irq` is `alarm_flag` AND `irq_en`.
- R6: With `on_backup` high, `alarm_irq` also requires `backup_irq_en`. With `backup_irq_en` low it stays 0 even when the flag is set.
- R7: A cycle with `flags_sel` and `flags_rd` both high clears `alarm_flag`, and with it `alarm_irq`, on the next edge. `flags_rd` alone, with `flags_sel` low, has no effect.
- R8: A hit while `flags_sel` is high does not raise the flag. The flag rises on the first edge at which `flags_sel` is low. A hit in the same cycle as a flags read is deferred in the same way.
- R9: When all repeat bits are 0 and the date value bits [5:0] of the alarm date register are 0, the alarm never fires.
- R10: Seconds and minutes compare bits [6:0]. Hours and date compare bits [5:0]. Bit 7 of the current seconds (the oscillator stop bit) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse after the time values update |
| cur_sec | input | 8 | Current seconds, BCD, bit 7 is the stop bit |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| alm_sec | input | 8 | Alarm seconds, bit 7 is repeat bit 1 |
| alm_min | input | 8 | Alarm minutes, bit 7 is repeat bit 2 |
| alm_hour | input | 8 | Alarm hours, bit 7 is repeat bit 3 |
| alm_date | input | 8 | Alarm date, bit 7 is repeat bit 4 |
| irq_en | input | 1 | Alarm flag enable for the interrupt |
| backup_irq_en | input | 1 | Allow the interrupt during backup power |
| on_backup | input | 1 | System runs on backup power |
| flags_sel | input | 1 | Flags register is the latched address |
| flags_rd | input | 1 | Read strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse. They also assume that `flags_rd` only means something while `flags_sel` is high, and that all inputs change only between clock edges. The bench drives every input on the falling edge and raises `sec_tick` for exactly one cycle at a time. It asserts reads only with `flags_sel` high, except in the one check that proves a read without `flags_sel` is ignored. The current-time values stay legal BCD, apart from the deliberate stop bit and the unused upper bits used for R10.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int FIELD_COUNT = 4;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_PEND = 2'd1,
        FL_SET  = 2'd2
    } flag_state_e;

    // Compare mask per field: seconds/minutes keep fw-1 bits, hours/date fw-2.
    function automatic logic [31:0] field_mask(input int idx, input int fw);
        int keep;
        keep = (idx < 2) ? (fw - 1) : (fw - 2);
        return (32'd1 << keep) - 32'd1;
    endfunction

    // Legal repeat code that compares the lowest k fields.
    function automatic logic [31:0] legal_code(input int k, input int nf);
        logic [31:0] ones;
        ones = (32'd1 << nf) - 32'd1;
        return (ones << k) & ones;
    endfunction

endpackage

// File: rtl/alarm_rpt_decode.sv
module alarm_rpt_decode #(
    parameter int NF = 4
) (
    input  logic [NF-1:0] rpt_bits,
    output logic [NF-1:0] cmp_en
);
    localparam int CW = $clog2(NF + 1);

    logic [CW-1:0] ncmp;

    // Legal codes are ones in the top, zeros in the bottom; anything else
    // falls back to comparing nothing (fires every tick).
    always_comb begin
        ncmp = '0;
        for (int k = 0; k <= NF; k++) begin
            logic [31:0] code;
            code = alarm_pkg::legal_code(k, NF);
            if (rpt_bits == code[NF-1:0]) begin
                ncmp = CW'(k);
            end
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_en
        assign cmp_en[i] = (ncmp > CW'(i));
    end

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int NF = 4,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] alm_vec,
    input  logic [NF*FW-1:0] cur_vec,
    input  logic [NF-1:0]    cmp_en,
    output logic             all_match
);
    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam logic [31:0]   MW = alarm_pkg::field_mask(i, FW);
        localparam logic [FW-1:0] M  = MW[FW-1:0];
        logic [FW-1:0] a_val;
        logic [FW-1:0] c_val;
        assign a_val       = alm_vec[i*FW +: FW] & M;
        assign c_val       = cur_vec[i*FW +: FW] & M;
        assign field_ok[i] = !cmp_en[i] || (a_val == c_val);
    end

    assign all_match = &field_ok;

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flags_sel,
    input  logic flags_rd,
    input  logic irq_en,
    input  logic backup_irq_en,
    input  logic on_backup,
    output logic alarm_flag,
    output logic alarm_irq
);
    flag_state_e state_q, state_d;
    logic        rd_clear;

    assign rd_clear = flags_sel && flags_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (hit) begin
                    state_d = flags_sel ? FL_PEND : FL_SET;
                end
            end
            FL_PEND: begin
                if (!flags_sel) begin
                    state_d = FL_SET;
                end
            end
            FL_SET: begin
                if (rd_clear) begin
                    state_d = hit ? FL_PEND : FL_IDLE;
                end
            end
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        alarm_flag = (state_q == FL_SET);
        alarm_irq  = alarm_flag && irq_en && (!on_backup || backup_irq_en);
    end

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_sel && flags_rd && alarm_flag) |=> !alarm_flag); // R7

    AST_NO_SET_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_sel && !alarm_flag) |=> !alarm_flag); // R8

    AST_SET_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !hit && state_q != FL_PEND) |=> !alarm_flag); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flag && irq_en)); // R5

    AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (on_backup && !backup_irq_en) |-> !alarm_irq); // R6

endmodule

// File: rtl/rtc_alarm_matcher.sv
module rtc_alarm_matcher #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [FW-1:0] cur_sec,
    input  logic [FW-1:0] cur_min,
    input  logic [FW-1:0] cur_hour,
    input  logic [FW-1:0] cur_date,
    input  logic [FW-1:0] alm_sec,
    input  logic [FW-1:0] alm_min,
    input  logic [FW-1:0] alm_hour,
    input  logic [FW-1:0] alm_date,
    input  logic          irq_en,
    input  logic          backup_irq_en,
    input  logic          on_backup,
    input  logic          flags_sel,
    input  logic          flags_rd,
    output logic          alarm_flag,
    output logic          alarm_irq
);
    localparam int NF = alarm_pkg::FIELD_COUNT;
    localparam logic [31:0]   DATE_MW   = alarm_pkg::field_mask(3, FW);
    localparam logic [FW-1:0] DATE_MASK = DATE_MW[FW-1:0];

    logic [NF*FW-1:0] alm_vec;
    logic [NF*FW-1:0] cur_vec;
    logic [NF-1:0]    rpt_bits;
    logic [NF-1:0]    cmp_en;
    logic             all_match;
    logic             disabled;
    logic             hit;

    assign alm_vec  = {alm_date, alm_hour, alm_min, alm_sec};
    assign cur_vec  = {cur_date, cur_hour, cur_min, cur_sec};
    assign rpt_bits = {alm_date[FW-1], alm_hour[FW-1], alm_min[FW-1], alm_sec[FW-1]};

    // Zero repeat bits together with a zero date value switch the alarm off.
    assign disabled = (rpt_bits == '0) && ((alm_date & DATE_MASK) == '0);
    assign hit      = sec_tick && all_match && !disabled;

    alarm_rpt_decode #(.NF(NF)) u_dec (
        .rpt_bits (rpt_bits),
        .cmp_en   (cmp_en)
    );

    alarm_field_cmp #(.NF(NF), .FW(FW)) u_cmp (
        .alm_vec   (alm_vec),
        .cur_vec   (cur_vec),
        .cmp_en    (cmp_en),
        .all_match (all_match)
    );

    alarm_flag_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit           (hit),
        .flags_sel     (flags_sel),
        .flags_rd      (flags_rd),
        .irq_en        (irq_en),
        .backup_irq_en (backup_irq_en),
        .on_backup     (on_backup),
        .alarm_flag    (alarm_flag),
        .alarm_irq     (alarm_irq)
    );

    AST_HIT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !alarm_flag && !flags_sel && !$past(flags_sel) && !$past(sec_tick))
        |=> !alarm_flag); // R4

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (disabled && !alarm_flag && !flags_sel && !$past(flags_sel)) |=> !alarm_flag); // R9

endmodule

// File: tb/tb_rtc_alarm_matcher.sv
module tb_rtc_alarm_matcher;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       sec_tick;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_date;
    logic [7:0] alm_sec, alm_min, alm_hour, alm_date;
    logic       irq_en, backup_irq_en, on_backup, flags_sel, flags_rd;
    logic       alarm_flag, alarm_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    rtc_alarm_matcher #(.FW(8)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
        .irq_en(irq_en), .backup_irq_en(backup_irq_en), .on_backup(on_backup),
        .flags_sel(flags_sel), .flags_rd(flags_rd),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Pulse the tick for one cycle; returns at the falling edge after it.
    task automatic pulse_tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic read_flags();
        @(negedge clk) begin flags_sel = 1'b1; flags_rd = 1'b1; end
        @(negedge clk) begin flags_rd = 1'b0; flags_sel = 1'b0; end
    endtask

    // Number of low fields the repeat code compares (R2, R3 fallback 0).
    function automatic int exp_ncmp(input logic [3:0] c);
        case (c)
            4'b1111: return 0;
            4'b1110: return 1;
            4'b1100: return 2;
            4'b1000: return 3;
            4'b0000: return 4;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0;
        cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00; cur_date = 8'h01;
        alm_sec = 8'h80; alm_min = 8'h80; alm_hour = 8'h80; alm_date = 8'h80;
        irq_en = 1'b1; backup_irq_en = 1'b0; on_backup = 1'b0;
        flags_sel = 1'b0; flags_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", alarm_flag, 1'b0);
        chk("R1 irq in reset", alarm_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after reset", alarm_flag, 1'b0);
        chk("R1 irq after reset", alarm_irq, 1'b0);

        // R2/R3 sweep: every repeat code against every field-mismatch pattern
        for (int code = 0; code < 16; code++) begin
            for (int m = 0; m < 16; m++) begin
                logic [3:0] c;
                logic [3:0] mm;
                int n;
                logic e;
                c  = code[3:0];
                mm = m[3:0];
                alm_sec  = {c[0], 7'h30};
                alm_min  = {c[1], 7'h15};
                alm_hour = {c[2], 7'h08};
                alm_date = {c[3], 7'h12};
                cur_sec  = mm[0] ? 8'h31 : 8'h30;
                cur_min  = mm[1] ? 8'h16 : 8'h15;
                cur_hour = mm[2] ? 8'h09 : 8'h08;
                cur_date = mm[3] ? 8'h13 : 8'h12;
                n = exp_ncmp(c);
                e = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    if (i < n && mm[i]) e = 1'b0;
                end
                pulse_tick();
                if (n == 0 && c != 4'b1111)
                    chk($sformatf("R3 code=%b mism=%b flag", c, mm), alarm_flag, e);
                else
                    chk($sformatf("R2 code=%b mism=%b flag", c, mm), alarm_flag, e);
                chk("R5 irq follows flag", alarm_irq, e);
                read_flags();
                chk("R7 read clears flag", alarm_flag, 1'b0);
                chk("R7 read clears irq", alarm_irq, 1'b0);
            end
        end

        // R4: matching time but no tick leaves the flag low
        alm_sec = 8'h80; alm_min = 8'h80; alm_hour = 8'h80; alm_date = 8'h80;
        repeat (4) @(negedge clk);
        chk("R4 no tick no flag", alarm_flag, 1'b0);
        pulse_tick();
        chk("R4 tick sets flag", alarm_flag, 1'b1);

        // R7: read strobe without flags_sel is ignored
        @(negedge clk) flags_rd = 1'b1;
        @(negedge clk) flags_rd = 1'b0;
        chk("R7 read without select ignored", alarm_flag, 1'b1);

        // R5/R6 interrupt gating
        irq_en = 1'b0; @(negedge clk);
        chk("R5 irq off without enable", alarm_irq, 1'b0);
        irq_en = 1'b1; on_backup = 1'b1; backup_irq_en = 1'b0; @(negedge clk);
        chk("R6 backup blocks irq", alarm_irq, 1'b0);
        chk("R6 flag still set in backup", alarm_flag, 1'b1);
        backup_irq_en = 1'b1; @(negedge clk);
        chk("R6 backup enable allows irq", alarm_irq, 1'b1);
        irq_en = 1'b0; @(negedge clk);
        chk("R6 backup needs flag enable too", alarm_irq, 1'b0);
        irq_en = 1'b1; on_backup = 1'b0; backup_irq_en = 1'b0;
        read_flags();

        // R8: hit while flags address latched is deferred
        @(negedge clk) begin flags_sel = 1'b1; sec_tick = 1'b1; end
        @(negedge clk) sec_tick = 1'b0;
        chk("R8 no flag while selected", alarm_flag, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 still held while selected", alarm_flag, 1'b0);
        flags_sel = 1'b0;
        @(negedge clk);
        chk("R8 flag after deselect", alarm_flag, 1'b1);

        // R8: read coinciding with a hit defers the new alarm
        @(negedge clk) begin flags_sel = 1'b1; flags_rd = 1'b1; sec_tick = 1'b1; end
        @(negedge clk) begin flags_rd = 1'b0; sec_tick = 1'b0; end
        chk("R8 read+hit drops flag", alarm_flag, 1'b0);
        flags_sel = 1'b0;
        @(negedge clk);
        chk("R8 read+hit flag returns", alarm_flag, 1'b1);
        read_flags();

        // R9: zero repeat bits and zero date disable the alarm
        alm_sec = 8'h00; alm_min = 8'h00; alm_hour = 8'h00; alm_date = 8'h00;
        cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00; cur_date = 8'h00;
        pulse_tick();
        chk("R9 disabled alarm silent", alarm_flag, 1'b0);
        alm_date = 8'h40; cur_date = 8'h00;
        pulse_tick();
        chk("R9 date upper bit does not enable", alarm_flag, 1'b0);

        // R10: compare widths and stop bit
        alm_sec = 8'h25; alm_min = 8'h15; alm_hour = 8'h48; alm_date = 8'h52;
        cur_sec = 8'hA5; cur_min = 8'h15; cur_hour = 8'h08; cur_date = 8'h12;
        pulse_tick();
        chk("R10 stop and upper bits ignored", alarm_flag, 1'b1);
        read_flags();
        cur_min = 8'h55;
        pulse_tick();
        chk("R10 minutes bit6 compared", alarm_flag, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule